// File: doc/BRIEF.md
# Hot-Plug Slot Command Executor

This block runs the command engine of a hot-plug controller that serves a small group of add-in card slots. A host hands it one 16-bit command word at a time. The low byte is the opcode and the high byte names the target slot, counted from 1. The block decodes the word and checks it against the present slot state and the per-slot retention-latch sensors. It then stays busy for a fixed number of cycles. At the end it commits the new state, reports a result code and latches a command-completed event that can raise an interrupt.

For each slot the block holds a 2-bit slot state, a 2-bit power-indicator state and a 2-bit attention-indicator state. It also holds one 4-bit bus speed/mode value. All of these leave the block as plain output fields, which downstream power sequencers, blink generators and bus logic follow. Commands arrive on a valid/ready channel. `cmd_ready` is high exactly when the engine is idle, and a word is taken only on a cycle where `cmd_valid` and `cmd_ready` are both high. The source may hold the word or withdraw it while `cmd_ready` is low. Nothing is queued, so a word withdrawn before the handshake leaves no trace. The interrupt control register is a plain write port with a read-back bus.

Top module: `hp_cmd_exec`

## Requirements
- R1: The command word carries the opcode in bits [7:0] and the target slot in bits [15:8], with slots numbered from 1. A word is accepted only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while busy, and a word offered then and withdrawn has no effect.
- R2: After acceptance, `cmd_status[0]` (busy) is high and `cmd_ready` is low for exactly LATENCY cycles. All state changes and result codes appear in the cycle in which busy falls.
- R3: Opcodes 0x00–0x3F are slot operations made of three independent 2-bit fields. Bits [1:0] set the slot state (1 power-only, 2 enabled, 3 disabled). Bits [3:2] set the power indicator and bits [5:4] set the attention indicator (1 on, 2 blink, 3 off). A field value of 0 keeps the item as it was, and no other slot changes.
- R4: A slot operation whose target is 0 or greater than NSLOT completes with the invalid-command flag `cmd_status[2]` and changes nothing.
- R5: A slot operation with slot-state field 1 or 2 whose target has `latch_open` high when the word is accepted completes with the latch-open flag `cmd_status[1]`. Nothing changes, the indicators included. Field values 0 and 3 are not refused.
- R6: Opcode 0x48 puts every slot into power-only and opcode 0x49 enables every slot, whatever the target byte holds. Both are refused with `cmd_status[1]` and change nothing if any `latch_open` bit is high.
- R7: Opcodes 0x40–0x44 set `bus_mode` to 0–4. With EXT_MODES=1, opcodes 0x50–0x5D set it to opcode−0x50 (0–13). If any slot is enabled, these commands complete with the invalid-speed flag `cmd_status[3]` and leave `bus_mode` unchanged.
- R8: All other opcodes complete with `cmd_status[2]` and change nothing. These are 0x45–0x47, 0x4A–0x4F, 0x5E–0x5F and 0x60–0xFF (vendor-specific codes included), and 0x50–0x5F when EXT_MODES=0.
- R9: The error flags `cmd_status[3:1]` clear when a word is accepted. They take the command's result when it completes and hold until the next acceptance. At most one of them is set.
- R10: Each completion sets the detect bit at bit 16 of the interrupt control register. Writing 1 to bit 16 clears it and writing 0 leaves it alone. A set on the same cycle as a clear wins.
- R11: Bit 2 of the interrupt control register is a read/write command-interrupt mask. `cmd_irq` is high exactly when the detect bit is set and the mask is clear. All other read-back bits are 0.
- R12: After reset every slot is disabled (3), both indicators of every slot are off (3), `bus_mode` is 0, the engine is idle, no error flag is set, detect is 0 and the mask is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Engine idle; a word is taken this cycle if valid |
| cmd_word | input | 16 | {target slot, opcode} |
| latch_open | input | NSLOT | Retention latch open, one bit per slot |
| cmd_status | output | 4 | {invalid speed, invalid command, latch open, busy} |
| ctl_wr | input | 1 | Write strobe for interrupt control register |
| ctl_wdata | input | 32 | Write data: bit 2 mask, bit 16 write-1-to-clear detect |
| ctl_rdata | output | 32 | Read-back: bit 2 mask, bit 16 detect |
| cmd_irq | output | 1 | Unmasked command-completed event pending |
| slot_state | output | 2*NSLOT | Slot state per slot, slot 1 in bits [1:0] |
| pwr_ind | output | 2*NSLOT | Power indicator state per slot |
| attn_ind | output | 2*NSLOT | Attention indicator state per slot |
| bus_mode | output | 4 | Bus speed/mode encoding |

## Verification
The bench builds the block with NSLOT=3, LATENCY=4 and EXT_MODES=1. With NSLOT=3, target bytes 4 and 255 fall outside the slot range, so range refusal is exercised on both sides. The short latency lets a command be offered while the engine is busy, and lets a detect-clear write land on the same edge as a completion. The extended-mode setting makes 0x5D reachable as a mode-13 write while 0x5E stays reserved.

// File: rtl/hp_cmd_pkg.sv
package hp_cmd_pkg;

  typedef enum logic [2:0] {
    K_NONE    = 3'd0,
    K_SLOT    = 3'd1,
    K_ALL_PWR = 3'd2,
    K_ALL_EN  = 3'd3,
    K_SPEED   = 3'd4
  } cmd_kind_e;

  localparam logic [1:0] FLD_KEEP     = 2'd0;
  localparam logic [1:0] ST_PWR_ONLY  = 2'd1;
  localparam logic [1:0] ST_ENABLED   = 2'd2;
  localparam logic [1:0] ST_DISABLED  = 2'd3;
  localparam logic [1:0] IND_OFF      = 2'd3;

  typedef struct packed {
    logic spd;    // invalid speed/mode
    logic inv;    // invalid command
    logic latch;  // retention latch open
  } cmd_err_t;

  typedef struct packed {
    cmd_kind_e  kind;
    logic [7:0] tgt;
    logic [1:0] sfld;
    logic [1:0] pfld;
    logic [1:0] afld;
    logic [3:0] mode;
    cmd_err_t   err;
  } cmd_plan_t;

endpackage

// File: rtl/hp_cmd_decode.sv
module hp_cmd_decode
  import hp_cmd_pkg::*;
#(
  parameter int NSLOT     = 4,
  parameter int EXT_MODES = 1
) (
  input  logic [15:0]        word,
  input  logic [NSLOT-1:0]   latch_open,
  input  logic [2*NSLOT-1:0] slot_state,
  output cmd_plan_t          plan
);

  localparam logic [7:0] LAST_SLOT = 8'(NSLOT);
  localparam bit         EXT_ON    = (EXT_MODES != 0);

  logic [7:0] op;
  logic [7:0] tgt;
  logic       any_enabled;
  logic       any_latched;
  logic       tgt_latched;
  logic       tgt_ok;

  assign op  = word[7:0];
  assign tgt = word[15:8];

  always_comb begin
    any_enabled = 1'b0;
    tgt_latched = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (slot_state[2*i +: 2] == ST_ENABLED) any_enabled = 1'b1;
      if (tgt == 8'(i + 1)) tgt_latched = latch_open[i];
    end
  end

  assign any_latched = |latch_open;
  assign tgt_ok      = (tgt != 8'd0) && (tgt <= LAST_SLOT);

  always_comb begin
    plan      = '0;
    plan.kind = K_NONE;
    plan.tgt  = tgt;
    plan.sfld = op[1:0];
    plan.pfld = op[3:2];
    plan.afld = op[5:4];
    plan.mode = op[4] ? op[3:0] : {1'b0, op[2:0]};
    if (op[7:6] == 2'b00) begin
      if (!tgt_ok)
        plan.err.inv = 1'b1;
      else if (tgt_latched &&
               (op[1:0] == ST_PWR_ONLY || op[1:0] == ST_ENABLED))
        plan.err.latch = 1'b1;
      else
        plan.kind = K_SLOT;
    end else if (op == 8'h48 || op == 8'h49) begin
      if (any_latched)
        plan.err.latch = 1'b1;
      else
        plan.kind = (op == 8'h48) ? K_ALL_PWR : K_ALL_EN;
    end else if ((op >= 8'h40 && op <= 8'h44) ||
                 (EXT_ON && op >= 8'h50 && op <= 8'h5D)) begin
      if (any_enabled)
        plan.err.spd = 1'b1;
      else
        plan.kind = K_SPEED;
    end else begin
      plan.err.inv = 1'b1;
    end
  end

endmodule

// File: rtl/hp_cmd_timer.sv
module hp_cmd_timer #(
  parameter int LATENCY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(LATENCY + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(LATENCY - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  assert_busy_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy);

  assert_done_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/hp_slot_bank.sv
module hp_slot_bank
  import hp_cmd_pkg::*;
#(
  parameter int NSLOT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               apply,
  input  cmd_plan_t          plan,
  output logic [2*NSLOT-1:0] slot_state,
  output logic [2*NSLOT-1:0] pwr_ind,
  output logic [2*NSLOT-1:0] attn_ind
);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic sel;
    assign sel = (plan.kind == K_SLOT) && (plan.tgt == 8'(i + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_state[2*i +: 2] <= ST_DISABLED;
        pwr_ind[2*i +: 2]    <= IND_OFF;
        attn_ind[2*i +: 2]   <= IND_OFF;
      end else if (apply) begin
        if (plan.kind == K_ALL_PWR) slot_state[2*i +: 2] <= ST_PWR_ONLY;
        if (plan.kind == K_ALL_EN)  slot_state[2*i +: 2] <= ST_ENABLED;
        if (sel) begin
          if (plan.sfld != FLD_KEEP) slot_state[2*i +: 2] <= plan.sfld;
          if (plan.pfld != FLD_KEEP) pwr_ind[2*i +: 2]    <= plan.pfld;
          if (plan.afld != FLD_KEEP) attn_ind[2*i +: 2]   <= plan.afld;
        end
      end
    end
  end

  assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> ($stable(slot_state) && $stable(pwr_ind) && $stable(attn_ind)));

endmodule

// File: rtl/hp_intr_ctl.sv
module hp_intr_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        done,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);

  localparam int MASK_BIT = 2;
  localparam int DET_BIT  = 16;

  logic det;
  logic mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det  <= 1'b0;
      mask <= 1'b1;
    end else begin
      if (wr) mask <= wdata[MASK_BIT];
      if (done)                      det <= 1'b1;
      else if (wr && wdata[DET_BIT]) det <= 1'b0;
    end
  end

  always_comb begin
    rdata           = '0;
    rdata[MASK_BIT] = mask;
    rdata[DET_BIT]  = det;
  end

  assign irq = det && !mask;

  assert_det_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> det);

  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[DET_BIT] && !done) |=> !det);

  assert_irq_low_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[MASK_BIT]) |=> !irq);

endmodule

// File: rtl/hp_cmd_exec.sv
module hp_cmd_exec
  import hp_cmd_pkg::*;
#(
  parameter int NSLOT     = 4,
  parameter int LATENCY   = 16,
  parameter int EXT_MODES = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [15:0]        cmd_word,
  input  logic [NSLOT-1:0]   latch_open,
  output logic [3:0]         cmd_status,
  input  logic               ctl_wr,
  input  logic [31:0]        ctl_wdata,
  output logic [31:0]        ctl_rdata,
  output logic               cmd_irq,
  output logic [2*NSLOT-1:0] slot_state,
  output logic [2*NSLOT-1:0] pwr_ind,
  output logic [2*NSLOT-1:0] attn_ind,
  output logic [3:0]         bus_mode
);

  cmd_plan_t plan_d;
  cmd_plan_t pend_q;
  cmd_err_t  err_q;
  logic      busy;
  logic      done;
  logic      accept;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && !busy;

  hp_cmd_decode #(.NSLOT(NSLOT), .EXT_MODES(EXT_MODES)) u_decode (
    .word       (cmd_word),
    .latch_open (latch_open),
    .slot_state (slot_state),
    .plan       (plan_d)
  );

  hp_cmd_timer #(.LATENCY(LATENCY)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .busy  (busy),
    .done  (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      err_q    <= '0;
      bus_mode <= '0;
    end else begin
      if (accept) begin
        pend_q <= plan_d;
        err_q  <= '0;
      end
      if (done) begin
        err_q <= pend_q.err;
        if (pend_q.kind == K_SPEED) bus_mode <= pend_q.mode;
      end
    end
  end

  hp_slot_bank #(.NSLOT(NSLOT)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .apply      (done),
    .plan       (pend_q),
    .slot_state (slot_state),
    .pwr_ind    (pwr_ind),
    .attn_ind   (attn_ind)
  );

  hp_intr_ctl u_intr (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (done),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .rdata (ctl_rdata),
    .irq   (cmd_irq)
  );

  assign cmd_status = {err_q.spd, err_q.inv, err_q.latch, busy};

  assert_err_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_status[3:1]));

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cmd_status[3:1] == 3'b000));

  assert_busy_ignores_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(pend_q));

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && pend_q.kind == K_SPEED) |=> $stable(bus_mode));

endmodule

// File: tb/hp_cmd_exec_tb_top.sv
`timescale 1ns/1ps
module hp_cmd_exec_tb_top;

  localparam int NS  = 3;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [15:0]   cmd_word = '0;
  logic [NS-1:0] latch_open = '0;
  logic [3:0]    cmd_status;
  logic          ctl_wr = 1'b0;
  logic [31:0]   ctl_wdata = '0;
  logic [31:0]   ctl_rdata;
  logic          cmd_irq;
  logic [2*NS-1:0] slot_state, pwr_ind, attn_ind;
  logic [3:0]    bus_mode;

  hp_cmd_exec #(.NSLOT(NS), .LATENCY(LAT), .EXT_MODES(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .latch_open(latch_open), .cmd_status(cmd_status),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .cmd_irq(cmd_irq), .slot_state(slot_state), .pwr_ind(pwr_ind),
    .attn_ind(attn_ind), .bus_mode(bus_mode)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;
  bit ended = 0;
  int cycles = 0;

  // behavioural reference model
  int m_st[NS], m_pw[NS], m_at[NS];
  int m_mode, m_cnt, m_err;
  bit m_busy, m_det, m_mask;
  int p_kind, p_tgt, p_op, p_err, p_mode;

  task automatic model_reset();
    for (int i = 0; i < NS; i++) begin m_st[i] = 3; m_pw[i] = 3; m_at[i] = 3; end
    m_mode = 0; m_cnt = 0; m_err = 0; m_busy = 0; m_det = 0; m_mask = 1;
    p_kind = 0; p_tgt = 0; p_op = 0; p_err = 0; p_mode = 0;
  endtask

  task automatic model_eval(input int w);
    int op, tg;
    bit anyen;
    op = w & 255; tg = (w >> 8) & 255;
    p_op = op; p_tgt = tg; p_kind = 0; p_err = 0;
    anyen = 0;
    for (int i = 0; i < NS; i++) if (m_st[i] == 2) anyen = 1;
    if (op <= 8'h3F) begin
      if (tg == 0 || tg > NS) p_err = 2;
      else if (latch_open[tg-1] && ((op & 3) == 1 || (op & 3) == 2)) p_err = 1;
      else p_kind = 1;
    end else if (op == 8'h48 || op == 8'h49) begin
      if (latch_open != 0) p_err = 1;
      else p_kind = (op == 8'h48) ? 2 : 3;
    end else if ((op >= 8'h40 && op <= 8'h44) || (op >= 8'h50 && op <= 8'h5D)) begin
      if (anyen) p_err = 4;
      else begin p_kind = 4; p_mode = (op >= 8'h50) ? op - 8'h50 : op - 8'h40; end
    end else p_err = 2;
  endtask

  task automatic model_commit();
    int ix;
    if (p_kind == 1) begin
      ix = p_tgt - 1;
      if ((p_op & 3) != 0)        m_st[ix] = p_op & 3;
      if (((p_op >> 2) & 3) != 0) m_pw[ix] = (p_op >> 2) & 3;
      if (((p_op >> 4) & 3) != 0) m_at[ix] = (p_op >> 4) & 3;
    end else if (p_kind == 2) begin
      for (int i = 0; i < NS; i++) m_st[i] = 1;
    end else if (p_kind == 3) begin
      for (int i = 0; i < NS; i++) m_st[i] = 2;
    end else if (p_kind == 4) m_mode = p_mode;
    m_err = p_err;
  endtask

  always @(posedge clk) begin
    bit acc, dn;
    if (!rst_n) model_reset();
    else begin
      acc = cmd_valid && !m_busy;
      dn = 0;
      if (m_busy) begin
        if (m_cnt == 0) begin dn = 1; m_busy = 0; end
        else m_cnt = m_cnt - 1;
      end
      if (dn) model_commit();
      if (ctl_wr) begin
        m_mask = ctl_wdata[2];
        if (ctl_wdata[16]) m_det = 0;
      end
      if (dn) m_det = 1;
      if (acc) begin
        model_eval(cmd_word);
        m_busy = 1; m_cnt = LAT - 1; m_err = 0;
      end
    end
    started = 1;
  end

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !ended) begin
      chk("R1 cmd_ready", int'(cmd_ready), int'(!m_busy));
      chk("R2 busy flag", int'(cmd_status[0]), int'(m_busy));
      chk("R4/R5/R6/R7/R8/R9 error flags", int'(cmd_status[3:1]), m_err);
      for (int i = 0; i < NS; i++) begin
        chk("R3/R6 slot state", int'(slot_state[2*i +: 2]), m_st[i]);
        chk("R3 power indicator", int'(pwr_ind[2*i +: 2]), m_pw[i]);
        chk("R3 attention indicator", int'(attn_ind[2*i +: 2]), m_at[i]);
      end
      chk("R7 bus mode", int'(bus_mode), m_mode);
      chk("R10/R11 control readback", int'(ctl_rdata), (int'(m_det) << 16) | (int'(m_mask) << 2));
      chk("R11 interrupt", int'(cmd_irq), int'(m_det && !m_mask));
    end
  end

  task automatic finish_run();
    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !ended) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic wait_idle();
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic issue(input logic [15:0] w);
    @(negedge clk);
    wait_idle();
    cmd_valid = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
  endtask

  // offer a second word for one busy cycle, then withdraw it (R1)
  task automatic issue_poke(input logic [15:0] w, input logic [15:0] poke);
    @(negedge clk);
    wait_idle();
    cmd_valid = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_word = poke;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
  endtask

  // detect-clear write landing on the completion edge (R10)
  task automatic issue_collide(input logic [15:0] w, input bit mask);
    @(negedge clk);
    wait_idle();
    cmd_valid = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = (32'd1 << 16) | (32'(mask) << 2);
    @(negedge clk);
    ctl_wr = 1'b0;
    wait_idle();
  endtask

  task automatic ctl_write(input logic [31:0] d);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state, checked directly
    chk("R12 reset slot state", int'(slot_state), 6'h3F);
    chk("R12 reset indicators", int'({pwr_ind, attn_ind}), 12'hFFF);
    chk("R12 reset status", int'(cmd_status), 0);
    chk("R12 reset control", int'(ctl_rdata), 32'h4);
    chk("R12 reset mode", int'(bus_mode), 0);

    ctl_write(32'h0);                 // unmask
    issue(16'h013A);                  // slot1 enable, pwr blink, attn off
    issue(16'h0201);                  // slot2 power-only
    issue(16'h0310);                  // slot3 attention on only
    issue(16'h0002);                  // target 0
    issue(16'h0402);                  // target beyond NS
    issue(16'hFF05);
    latch_open = 3'b010;
    issue(16'h0202);                  // refused, latch open
    issue(16'h0201);
    issue(16'h020F);                  // disable + pwr off allowed
    issue(16'h0048);                  // refused: any latch
    latch_open = 3'b000;
    issue(16'h0043);                  // slot1 enabled -> invalid speed
    issue(16'h0103);
    issue(16'h0043);                  // mode 3
    issue(16'h0048);                  // all power-only
    issue(16'h0049);                  // all enabled
    issue(16'h0044);                  // invalid speed
    issue(16'h0103); issue(16'h0203); issue(16'h0303);
    issue(16'h005D);                  // mode 13
    issue(16'h0050);                  // mode 0
    issue(16'h005E); issue(16'h0047); issue(16'h004A);
    issue(16'h0080); issue(16'h00C5); issue(16'h00FF);
    issue_poke(16'h0125, 16'h0249);   // poke while busy is not taken
    ctl_write(32'h0);                 // write 0: detect stays
    ctl_write(32'h10000);             // clear detect
    issue_collide(16'h0211, 1'b0);    // set wins over clear
    ctl_write(32'h4);                 // mask
    issue(16'h0122);
    ctl_write(32'h10004);
    ctl_write(32'h0);
    issue(16'h0304);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule